// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of general-purpose pins with a memory-mapped register port. Software sets each pin's direction and output value, reads back its synchronized input level, and sets up per-pin interrupt detection. Detection runs on either edges or levels. A programmable polarity picks one edge direction (rising or falling) or one active level (high or low). The bank has no both-edges mode.

Each pin has two enables for an interrupt. One decides whether the pin's sticky status bit records a trigger. The other decides whether the trigger reaches the interrupt output. A pin can therefore raise the interrupt while its status bit stays clear. A per-pin routing code picks the destination processor. Only pins routed to the application processor feed the single summary interrupt line.

The register port is a single-cycle write strobe with a combinational read of the addressed register. The pin count is a parameter and is kept small for simulation.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, except each routing register, which reads 7. `pin_oe`, `pin_out` and `irq_summary` are 0.
- R2: The registers of pin i are word-aligned at these addresses: direction register at 0x1000+16i, data register at 0x1004+16i, trigger-setup register at 0x1008+16i, status register at 0x100C+16i. The routing register of pin i is at 0x400+4i. Each written field reads back.
- R3: Bit 9 of the direction register drives `pin_oe[i]`. Bit 1 of the data register drives `pin_out[i]`. Neither output changes except in the cycle after a write.
- R4: Bit 0 of the data register reads `pin_in[i]` through a two-flop synchronizer. A change driven before clock edge k is readable after edge k+1.
- R5: Trigger-setup bit 2 = 1 selects edge detection. Bit 1 (polarity) = 1 selects the rising edge and 0 selects the falling edge. The opposite edge triggers nothing. Status reflects an input change after the third rising clock edge.
- R6: Trigger-setup bit 2 = 0 selects level detection. The trigger is active while the synchronized input equals the polarity bit.
- R7: Status bit 0 is set by a trigger only when trigger-setup bit 3 (record enable) is 1.
- R8: With trigger-setup bit 0 (interrupt enable) at 1, a trigger reaches the interrupt even when bit 3 is 0. With bit 0 at 0 the pin never contributes.
- R9: Writing 1 to status bit 0 clears that bit and the pin's latched edge. Writing 0 changes nothing. A trigger in the same cycle wins over the clear. A level trigger that is still active sets the bit again.
- R10: Only routing code 4 (application processor) lets a pin contribute to `irq_summary`. Code 7 (no processor) blocks it.
- R11: `irq_summary` is the OR over pins of enable AND routed-to-4 AND pending. Pending is the latched edge in edge mode and the live active level in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 13 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr (combinational) |
| pin_in | input | N_PINS | Asynchronous pin input levels |
| pin_oe | output | N_PINS | Per-pin output enable |
| pin_out | output | N_PINS | Per-pin driven output value |
| irq_summary | output | 1 | Aggregated interrupt to the application processor |

## Verification
The hardest case to reach is a pin that raises the interrupt while its status bit stays clear. The same difficulty applies to telling a latched edge from a live level once the input has returned to its idle level. Both cases depend on one setup word and one routing code, and they show up only after a full drive–release–clear sequence. The bench therefore sweeps all sixteen trigger-setup words against both routing codes on every pin. Each time, it parks the input at the idle level for that polarity, drives the active level, clears the status, releases the input and clears again. It computes the expected status and interrupt at each step from the setup bits.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and the trigger-setup field layout for gpio_bank.
// Assumes a byte-addressed register port of ADDR_W bits and DATA_W-bit words.
package gpio_bank_pkg;
    localparam int ADDR_W      = 13;
    localparam int DATA_W      = 32;
    localparam int ROUTE_W     = 3;
    localparam logic [ADDR_W-1:0] PIN_BASE   = 13'h1000;
    localparam logic [ADDR_W-1:0] ROUTE_BASE = 13'h0400;
    localparam int PIN_STRIDE   = 16;
    localparam int ROUTE_STRIDE = 4;
    // byte offsets inside one pin's register block
    localparam int OFS_DIR  = 0;
    localparam int OFS_DATA = 4;
    localparam int OFS_TRIG = 8;
    localparam int OFS_STAT = 12;
    // field positions
    localparam int DIR_OE_BIT   = 9;
    localparam int DATA_IN_BIT  = 0;
    localparam int DATA_OUT_BIT = 1;
    localparam int STAT_BIT     = 0;
    localparam logic [ROUTE_W-1:0] ROUTE_APP  = 3'd4;
    localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

    // trigger-setup word, bits 3..0
    typedef struct packed {
        logic rec_en;    // bit 3: record trigger in status
        logic edge_mode; // bit 2: 1 edge, 0 level
        logic pol;       // bit 1: 1 rising/high, 0 falling/low
        logic irq_en;    // bit 0: trigger reaches interrupt
    } trig_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no cross-bit coherence is needed.
module gpio_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // capture and re-time the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pin_slice.sv
// Module: register state and trigger detection for one pin.
// Assumes in_sync is already synchronized; write strobes are pre-decoded.
module gpio_pin_slice
    import gpio_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_sync,
    input  logic               wr_dir,
    input  logic               wr_data,
    input  logic               wr_trig,
    input  logic               wr_stat,
    input  logic               wr_route,
    input  logic               wd_oe,
    input  logic               wd_out,
    input  trig_cfg_t          wd_trig,
    input  logic               wd_clear,
    input  logic [ROUTE_W-1:0] wd_route,
    output logic               oe,
    output logic               out_val,
    output trig_cfg_t          trig,
    output logic [ROUTE_W-1:0] route,
    output logic               status,
    output logic               pending,
    output logic               edge_lat
);
    logic prev_in;
    logic edge_hit;
    logic level_hit;
    logic fire;
    logic clr;

    // previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_in <= 1'b0;
        else        prev_in <= in_sync;
    end

    // edge of the selected direction, level of the selected polarity
    always_comb begin
        edge_hit  = trig.pol ? (in_sync & ~prev_in) : (~in_sync & prev_in);
        level_hit = (in_sync == trig.pol);
        fire      = trig.edge_mode ? edge_hit : level_hit;
        clr       = wr_stat & wd_clear;
    end

    // software-visible configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe      <= 1'b0;
            out_val <= 1'b0;
            trig    <= '0;
            route   <= ROUTE_NONE;
        end else begin
            if (wr_dir)   oe      <= wd_oe;
            if (wr_data)  out_val <= wd_out;
            if (wr_trig)  trig    <= wd_trig;
            if (wr_route) route   <= wd_route;
        end
    end

    // sticky status: set by a recorded trigger, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)                   status <= 1'b0;
        else if (fire & trig.rec_en)  status <= 1'b1;
        else if (clr)                 status <= 1'b0;
    end

    // interrupt-side edge latch, independent of the status record
    always_ff @(posedge clk) begin
        if (!rst_n)                                        edge_lat <= 1'b0;
        else if (trig.edge_mode & trig.irq_en & edge_hit)  edge_lat <= 1'b1;
        else if (clr)                                      edge_lat <= 1'b0;
    end

    // pending request seen by the aggregator
    assign pending = trig.edge_mode ? edge_lat : level_hit;
endmodule

// File: rtl/gpio_bank.sv
// Module: GPIO bank top; decodes the register port, instantiates one slice
// per pin and aggregates routed interrupts into one summary line.
// Assumes N_PINS <= 256 so every register fits the address space.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_out,
    output logic              irq_summary
);
    localparam int TRIG_W = $bits(trig_cfg_t);

    logic [N_PINS-1:0]  in_sync;
    logic [N_PINS-1:0]  status_v;
    logic [N_PINS-1:0]  pend_v;
    logic [N_PINS-1:0]  edge_lat_v;
    logic [N_PINS-1:0]  irq_en_v;
    logic [N_PINS-1:0]  rec_en_v;
    logic [N_PINS-1:0]  edge_mode_v;
    logic [N_PINS-1:0]  route_app_v;
    trig_cfg_t          trig_v  [N_PINS];
    logic [ROUTE_W-1:0] route_v [N_PINS];
    trig_cfg_t          wd_trig;
    logic [DATA_W-1:0]  unused_wdata;

    assign wd_trig      = trig_cfg_t'(bus_wdata[TRIG_W-1:0]);
    assign unused_wdata = bus_wdata;

    gpio_sync #(.W(N_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (in_sync)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        localparam logic [ADDR_W-1:0] BLK = PIN_BASE + ADDR_W'(PIN_STRIDE * i);
        localparam logic [ADDR_W-1:0] RTA = ROUTE_BASE + ADDR_W'(ROUTE_STRIDE * i);
        logic hit_dir, hit_data, hit_trig, hit_stat, hit_route;

        // per-pin write decode
        always_comb begin
            hit_dir   = bus_wr && (bus_addr == BLK + ADDR_W'(OFS_DIR));
            hit_data  = bus_wr && (bus_addr == BLK + ADDR_W'(OFS_DATA));
            hit_trig  = bus_wr && (bus_addr == BLK + ADDR_W'(OFS_TRIG));
            hit_stat  = bus_wr && (bus_addr == BLK + ADDR_W'(OFS_STAT));
            hit_route = bus_wr && (bus_addr == RTA);
        end

        gpio_pin_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_sync  (in_sync[i]),
            .wr_dir   (hit_dir),
            .wr_data  (hit_data),
            .wr_trig  (hit_trig),
            .wr_stat  (hit_stat),
            .wr_route (hit_route),
            .wd_oe    (bus_wdata[DIR_OE_BIT]),
            .wd_out   (bus_wdata[DATA_OUT_BIT]),
            .wd_trig  (wd_trig),
            .wd_clear (bus_wdata[STAT_BIT]),
            .wd_route (bus_wdata[ROUTE_W-1:0]),
            .oe       (pin_oe[i]),
            .out_val  (pin_out[i]),
            .trig     (trig_v[i]),
            .route    (route_v[i]),
            .status   (status_v[i]),
            .pending  (pend_v[i]),
            .edge_lat (edge_lat_v[i])
        );

        // unpack per-pin fields for aggregation and checking
        always_comb begin
            irq_en_v[i]    = trig_v[i].irq_en;
            rec_en_v[i]    = trig_v[i].rec_en;
            edge_mode_v[i] = trig_v[i].edge_mode;
            route_app_v[i] = (route_v[i] == ROUTE_APP);
        end
    end

    // summary line: enabled, routed to the application processor, pending
    assign irq_summary = |(irq_en_v & route_app_v & pend_v);

    // combinational read of the addressed register
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_PINS; i++) begin
            if (bus_addr == PIN_BASE + ADDR_W'(PIN_STRIDE * i + OFS_DIR))
                bus_rdata[DIR_OE_BIT] = pin_oe[i];
            if (bus_addr == PIN_BASE + ADDR_W'(PIN_STRIDE * i + OFS_DATA)) begin
                bus_rdata[DATA_IN_BIT]  = in_sync[i];
                bus_rdata[DATA_OUT_BIT] = pin_out[i];
            end
            if (bus_addr == PIN_BASE + ADDR_W'(PIN_STRIDE * i + OFS_TRIG))
                bus_rdata[TRIG_W-1:0] = trig_v[i];
            if (bus_addr == PIN_BASE + ADDR_W'(PIN_STRIDE * i + OFS_STAT))
                bus_rdata[STAT_BIT] = status_v[i];
            if (bus_addr == ROUTE_BASE + ADDR_W'(ROUTE_STRIDE * i))
                bus_rdata[ROUTE_W-1:0] = route_v[i];
        end
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// Module: assertion checker for gpio_bank, attached by bind below.
// Assumes the synchronous active-low reset of the bank it observes.
module gpio_bank_chk #(
    parameter int N_PINS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [N_PINS-1:0] pin_oe,
    input logic [N_PINS-1:0] pin_out,
    input logic              irq_summary,
    input logic [N_PINS-1:0] status_v,
    input logic [N_PINS-1:0] edge_lat_v,
    input logic [N_PINS-1:0] rec_en_v
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_summary && pin_oe == '0 && pin_out == '0)); // R1

    AST_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> ($stable(pin_oe) && $stable(pin_out))); // R3

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin_chk
        AST_STATUS_NEEDS_REC: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_v[i]) |-> $past(rec_en_v[i])); // R7

        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (status_v[i] && !bus_wr) |=> status_v[i]); // R9

        AST_EDGE_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_lat_v[i] && !bus_wr) |=> edge_lat_v[i]); // R9
    end
endmodule

bind gpio_bank gpio_bank_chk #(.N_PINS(N_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out),
    .irq_summary (irq_summary),
    .status_v    (status_v),
    .edge_lat_v  (edge_lat_v),
    .rec_en_v    (rec_en_v)
);

// File: tb/gpio_bank_test.sv
// Bench: sweeps every trigger setup and routing code over every pin of a
// four-pin bank; expected values come from the requirement text.
module gpio_bank_test;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_oe;
    logic [N-1:0] pin_out;
    logic        irq_summary;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_bank #(.N_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq_summary(irq_summary)
    );

    function automatic logic [12:0] a_dir(int i);   return 13'(16'h1000 + 16 * i); endfunction
    function automatic logic [12:0] a_data(int i);  return 13'(16'h1004 + 16 * i); endfunction
    function automatic logic [12:0] a_trig(int i);  return 13'(16'h1008 + 16 * i); endfunction
    function automatic logic [12:0] a_stat(int i);  return 13'(16'h100C + 16 * i); endfunction
    function automatic logic [12:0] a_route(int i); return 13'(16'h0400 + 4 * i);  endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        chk("R1 irq", 32'(irq_summary), 0);
        chk("R1 oe", 32'(pin_oe), 0);
        chk("R1 out", 32'(pin_out), 0);
        for (int i = 0; i < N; i++) begin
            rd(a_dir(i), d);   chk("R1 dir", d, 0);
            rd(a_trig(i), d);  chk("R1 trig", d, 0);
            rd(a_stat(i), d);  chk("R1 stat", d, 0);
            rd(a_route(i), d); chk("R1 route", d, 7);
        end

        // R3 / R2: every direction/value pattern
        for (int v = 0; v < 16; v++) begin
            for (int i = 0; i < N; i++) begin
                wr(a_dir(i), 32'(v[i]) << 9);
                wr(a_data(i), 32'(~v[i] & 1) << 1);
            end
            chk("R3 oe", 32'(pin_oe), 32'(v));
            chk("R3 out", 32'(pin_out), 32'(~v & 15));
            for (int i = 0; i < N; i++) begin
                rd(a_dir(i), d);  chk("R2 dir readback", d, 32'(v[i]) << 9);
                rd(a_data(i), d); chk("R2 data out readback", d & 2, 32'(~v[i] & 1) << 1);
            end
        end

        // R4: input patterns through synchronizer
        for (int v = 0; v < 16; v++) begin
            pin_in = 4'(v);
            idle(2);
            for (int i = 0; i < N; i++) begin
                rd(a_data(i), d); chk("R4 input", d & 1, 32'(v[i]));
            end
        end
        // R4: latency
        @(negedge clk); pin_in[3] = 1'b0; idle(3);
        @(negedge clk); pin_in[3] = 1'b1;
        idle(1); rd(a_data(3), d); chk("R4 latency early", d & 1, 0);
        idle(1); rd(a_data(3), d); chk("R4 latency", d & 1, 1);
        pin_in = '0;
        idle(3);

        // R5..R10: full sweep of setup word and routing code
        for (int p = 0; p < N; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int k = 0; k < 2; k++) begin
                    logic en, pol, edg, rec, ap;
                    logic [2:0] r;
                    r   = (k == 0) ? 3'd4 : 3'd7;
                    en  = c[0]; pol = c[1]; edg = c[2]; rec = c[3];
                    ap  = (r == 3'd4);
                    wr(a_trig(p), 0);
                    wr(a_route(p), 32'(r));
                    pin_in[p] = ~pol;
                    idle(4);
                    wr(a_trig(p), 32'(c));
                    wr(a_stat(p), 1);
                    idle(2);
                    rd(a_trig(p), d);  chk("R2 trig readback", d, 32'(c));
                    rd(a_route(p), d); chk("R2 route readback", d, 32'(r));
                    rd(a_stat(p), d);  chk("R6 idle status", d, 0);
                    chk("R5 idle irq", 32'(irq_summary), 0);
                    // drive active edge / level
                    @(negedge clk); pin_in[p] = pol;
                    idle(4);
                    wr(a_stat(p), 0);
                    rd(a_stat(p), d);  chk("R7 status on trigger", d, 32'(rec));
                    chk("R8 R10 irq on trigger", 32'(irq_summary), 32'(en & ap));
                    // clear while active
                    wr(a_stat(p), 1);
                    idle(2);
                    rd(a_stat(p), d);
                    chk("R9 status after clear", d, 32'(edg ? 1'b0 : rec));
                    chk("R9 irq after clear", 32'(irq_summary), 32'(edg ? 1'b0 : (en & ap)));
                    // release: opposite edge / inactive level
                    @(negedge clk); pin_in[p] = ~pol;
                    idle(4);
                    rd(a_stat(p), d);
                    chk("R5 R6 status after release", d, 32'(edg ? 1'b0 : rec));
                    chk("R5 R6 irq after release", 32'(irq_summary), 0);
                    wr(a_stat(p), 1);
                    idle(1);
                    rd(a_stat(p), d);  chk("R9 final status", d, 0);
                    chk("R9 final irq", 32'(irq_summary), 0);
                end
            end
            wr(a_trig(p), 0);
            wr(a_route(p), 7);
        end

        // R5: status timing for a rising edge (setup 0xE)
        pin_in = '0;
        wr(a_trig(1), 32'hE);
        idle(3);
        wr(a_stat(1), 1);
        @(negedge clk); pin_in[1] = 1'b1;
        idle(2); rd(a_stat(1), d); chk("R5 status not before 3rd edge", d, 0);
        idle(1); rd(a_stat(1), d); chk("R5 status at 3rd edge", d, 1);
        wr(a_trig(1), 0);
        wr(a_stat(1), 1);
        pin_in = '0;
        idle(3);

        // R11: OR of two pins, rising edge, enabled, recorded, routed to 4
        wr(a_trig(0), 32'hF); wr(a_route(0), 4);
        wr(a_trig(2), 32'hF); wr(a_route(2), 4);
        wr(a_stat(0), 1); wr(a_stat(2), 1);
        idle(1);
        chk("R11 none pending", 32'(irq_summary), 0);
        @(negedge clk); pin_in[2] = 1'b1; idle(4);
        chk("R11 one pin", 32'(irq_summary), 1);
        wr(a_stat(2), 1); idle(1);
        chk("R11 cleared", 32'(irq_summary), 0);
        @(negedge clk); pin_in[0] = 1'b1; pin_in[2] = 1'b0; idle(2);
        @(negedge clk); pin_in[2] = 1'b1; idle(4);
        chk("R11 both pending", 32'(irq_summary), 1);
        wr(a_stat(0), 1); idle(1);
        chk("R11 one of two cleared", 32'(irq_summary), 1);
        wr(a_stat(2), 1); idle(1);
        chk("R11 both cleared", 32'(irq_summary), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule